// File: doc/BRIEF.md
# Serial Port Controller with Frame Control

The block is an asynchronous serial transmitter/receiver reached through a small 32-bit register port. Software writes characters into a transmit queue and reads received characters from a receive queue. Each received character carries its own error flags, which can be read at a separate status word before the character is taken from the queue. A baud divisor, split over two byte-wide registers, sets the bit rate to clk / (16 × (divisor + 1)). A line-format register selects 5 to 8 data bits, parity off, odd or even, one or two stop bits, queue mode and a forced break.

Three modem inputs (clear-to-send, data-set-ready, carrier-detect) are visible as flags, and any change on them raises a latched cause. Interrupt causes for the receive level, receive timeout, transmit level and modem change are masked by separate enable bits and merged onto one active-high interrupt line.

Top module: `ser_link`

## Requirements
- R1: After reset the flag word (offset 0x18) reads 0x90 with modem inputs low (bit7 transmitter fully empty, bit4 receive queue empty), the line word (0x08), error word (0x04) and interrupt word (0x1C) read 0, txd is high and irq is low.
- R2: The divisor is {byte at 0x0C, byte at 0x10}; every serial bit lasts 16 × (divisor + 1) clock cycles.
- R3: A transmitted frame is a low start bit, the data bits LSB first (count 5 + line[6:5]), a parity bit when line[1] is set (even when line[2] is set, else odd), then one stop bit, or two when line[3] is set; an idle line is high.
- R4: The receiver samples each bit at tick 7 of 16 and returns the data bits in data[7:0] with upper unused bits zero; a character sent in any format is read back unchanged.
- R5: While line[0] is set, txd is held low.
- R6: The error word describes the character at the head of the receive queue before it is popped: bit0 stop bit low, bit1 parity mismatch; any write to offset 0x04 clears all error bits.
- R7: A character whose data, parity and first stop bit are all zero reports bit2 (break) of the error word and neither framing nor parity error.
- R8: With line[4] clear each queue holds one character; a character arriving while the receive queue is full is discarded and sets error bit3, which stays until offset 0x04 is written.
- R9: With line[4] set each queue holds 16 characters in order; a write to a full transmit queue is ignored; flag bit5 is transmit-queue full; changing line[4] empties both queues.
- R10: Interrupt bit1 is set while the receive queue holds 8 or more characters (queue mode) or any character (single mode) and control bit4 is set; irq follows the OR of the enabled causes one cycle later.
- R11: Interrupt bit2 is set while the transmit queue holds 8 or fewer characters (queue mode) or is empty (single mode) and control bit5 is set.
- R12: Interrupt bit3 (with control bit6) is raised when the receive queue has been non-empty for 32 bit periods with no new start bit; a data read clears it.
- R13: Flag bits 2:0 show carrier-detect, data-set-ready and clear-to-send; a change on any of them latches interrupt bit0 (with control bit3), cleared by a write to offset 0x1C.
- R14: A start bit that is high again at its mid-point is discarded and yields no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Merged interrupt, active high |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| cts | input | 1 | Clear-to-send level |
| dsr | input | 1 | Data-set-ready level |
| dcd | input | 1 | Carrier-detect level |

## Verification
On every cycle the assertions hold the forced-break level and idle-high line of the transmitter, the ignored push into a full transmit queue, the one-entry limit of the receive queue in single mode, the interrupt line following an enabled receive cause, the timeout cause dropping after a data read, and the latching of a modem change. Frame layout across all word lengths, parity modes and stop counts, bit timing for different divisors, per-character error reporting, break priority, overrun, queue ordering and the timeout window can only be shown by the bench's scenarios, which build the expected serial bit patterns and register words arithmetically and drive the receiver directly or through a loopback.

// File: rtl/ser_link_pkg.sv
package ser_link_pkg;

    localparam logic [4:0] OFS_DATA = 5'h00;
    localparam logic [4:0] OFS_ERR  = 5'h04;
    localparam logic [4:0] OFS_LINE = 5'h08;
    localparam logic [4:0] OFS_DIVH = 5'h0C;
    localparam logic [4:0] OFS_DIVL = 5'h10;
    localparam logic [4:0] OFS_CTRL = 5'h14;
    localparam logic [4:0] OFS_FLAG = 5'h18;
    localparam logic [4:0] OFS_INT  = 5'h1C;

    // Line-format word; field positions are software visible.
    typedef struct packed {
        logic [1:0] wlen;      // 6:5 data bits minus five
        logic       fifo_en;   // 4
        logic       two_stop;  // 3
        logic       par_even;  // 2
        logic       par_en;    // 1
        logic       brk_tx;    // 0
    } line_t;

    typedef struct packed {
        logic [7:0] data;
        logic       brk;
        logic       perr;
        logic       ferr;
    } rx_word_t;

    typedef enum logic [2:0] {
        SL_IDLE, SL_START, SL_DATA, SL_PAR, SL_STOP
    } ser_state_e;

    function automatic logic [7:0] data_mask(input logic [1:0] wlen);
        return 8'hFF >> (2'd3 - wlen);
    endfunction

    function automatic logic [2:0] last_idx(input logic [1:0] wlen);
        return {1'b1, wlen};
    endfunction

    function automatic logic par_calc(input logic [7:0] d, input logic even);
        return even ? (^d) : ~(^d);
    endfunction

endpackage

// File: rtl/ser_fifo.sv
module ser_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          single,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = single ? !empty : (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/ser_baud.sv
module ser_baud #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] cnt;

    assign tick = en && (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst || !en)   cnt <= '0;
        else if (tick)    cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ser_tx.sv
module ser_tx
    import ser_link_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       en,
    input  line_t      line,
    input  logic       have,
    input  logic [7:0] din,
    output logic       pop,
    output logic       txd,
    output logic       busy
);
    ser_state_e st;
    logic [3:0] sub;
    logic [2:0] bitn;
    logic       stop2;
    logic [7:0] cur;
    logic       bitval;

    assign pop  = (st == SL_IDLE) && en && have;
    assign busy = (st != SL_IDLE);

    always_comb begin
        case (st)
            SL_START: bitval = 1'b0;
            SL_DATA:  bitval = cur[bitn];
            SL_PAR:   bitval = par_calc(cur, line.par_even);
            default:  bitval = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SL_IDLE;
            sub   <= '0;
            bitn  <= '0;
            stop2 <= 1'b0;
            cur   <= '0;
            txd   <= 1'b1;
        end else begin
            txd <= line.brk_tx ? 1'b0 : bitval;
            if (st == SL_IDLE) begin
                if (pop) begin
                    cur   <= din & data_mask(line.wlen);
                    st    <= SL_START;
                    sub   <= '0;
                    bitn  <= '0;
                    stop2 <= 1'b0;
                end
            end else if (tick) begin
                sub <= sub + 1'b1;
                if (sub == 4'd15) begin
                    case (st)
                        SL_START: st <= SL_DATA;
                        SL_DATA: begin
                            if (bitn == last_idx(line.wlen))
                                st <= line.par_en ? SL_PAR : SL_STOP;
                            else
                                bitn <= bitn + 1'b1;
                        end
                        SL_PAR: st <= SL_STOP;
                        SL_STOP: begin
                            if (line.two_stop && !stop2) stop2 <= 1'b1;
                            else                         st    <= SL_IDLE;
                        end
                        default: st <= SL_IDLE;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/ser_rx.sv
module ser_rx
    import ser_link_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     en,
    input  line_t    line,
    input  logic     rxd,
    output logic     push,
    output rx_word_t word,
    output logic     start_seen
);
    ser_state_e st;
    logic [3:0] sub;
    logic [2:0] bitn;
    logic [7:0] shreg;
    logic       par_rx;
    logic       rxd_prev;
    logic       zero_all, pbad;

    assign pbad     = line.par_en && (par_rx != par_calc(shreg, line.par_even));
    assign zero_all = (shreg == '0) && !rxd && (!line.par_en || !par_rx);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= SL_IDLE;
            sub        <= '0;
            bitn       <= '0;
            shreg      <= '0;
            par_rx     <= 1'b0;
            rxd_prev   <= 1'b1;
            push       <= 1'b0;
            start_seen <= 1'b0;
            word       <= '0;
        end else begin
            push       <= 1'b0;
            start_seen <= 1'b0;
            rxd_prev   <= rxd;
            if (st == SL_IDLE) begin
                if (en && rxd_prev && !rxd) begin
                    st         <= SL_START;
                    sub        <= '0;
                    bitn       <= '0;
                    shreg      <= '0;
                    start_seen <= 1'b1;
                end
            end else if (tick) begin
                sub <= sub + 1'b1;
                if (sub == 4'd7) begin
                    case (st)
                        SL_START: if (rxd) st <= SL_IDLE;
                        SL_DATA:  shreg[bitn] <= rxd;
                        SL_PAR:   par_rx <= rxd;
                        SL_STOP: begin
                            push      <= 1'b1;
                            word.data <= shreg;
                            word.brk  <= zero_all;
                            word.perr <= pbad && !zero_all;
                            word.ferr <= !rxd && !zero_all;
                            st        <= SL_IDLE;
                        end
                        default: st <= SL_IDLE;
                    endcase
                end else if (sub == 4'd15) begin
                    case (st)
                        SL_START: st <= SL_DATA;
                        SL_DATA: begin
                            if (bitn == last_idx(line.wlen))
                                st <= line.par_en ? SL_PAR : SL_STOP;
                            else
                                bitn <= bitn + 1'b1;
                        end
                        SL_PAR:  st <= SL_STOP;
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/ser_link.sv
module ser_link
    import ser_link_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int DIV_W        = 16,
    parameter int TIMEOUT_BITS = 32,
    localparam int CW          = $clog2(DEPTH) + 1,
    localparam int TO_TICKS    = TIMEOUT_BITS * 16,
    localparam int TW          = $clog2(TO_TICKS + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    input  logic        rxd,
    output logic        txd,
    input  logic        cts,
    input  logic        dsr,
    input  logic        dcd
);
    localparam logic [CW-1:0] HALF    = CW'(DEPTH / 2);
    localparam logic [TW-1:0] TO_LAST = TW'(TO_TICKS - 1);

    line_t            line_r;
    logic [DIV_W-1:0] div_r;
    logic [6:0]       ctrl_r;
    logic             wr_en, rd_en, wr_data, rd_data, fifo_flush;
    logic             tick;
    logic             tx_empty, tx_full, tx_pop, tx_busy;
    logic [7:0]       tx_head;
    logic [CW-1:0]    tx_cnt, rx_cnt;
    logic             rx_push, rx_empty, rx_full, start_seen, pop_ok;
    rx_word_t         rx_word, rx_head;
    logic             rxd_s1, rxd_s2;
    logic [2:0]       mod_now, mod_prev;
    logic             mis, rtis, ris, tis, ovr, err_hide;
    logic [TW-1:0]    to_cnt;
    logic [3:0]       int_view;
    logic             unused_bits;

    assign unused_bits = ^bus_wdata[31:8];
    assign wr_en      = bus_sel && bus_wr;
    assign rd_en      = bus_sel && !bus_wr;
    assign wr_data    = wr_en && (bus_addr == OFS_DATA);
    assign rd_data    = rd_en && (bus_addr == OFS_DATA);
    assign pop_ok     = rd_data && !rx_empty;
    assign fifo_flush = wr_en && (bus_addr == OFS_LINE) && (bus_wdata[4] != line_r.fifo_en);

    // Configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            line_r <= '0;
            div_r  <= '0;
            ctrl_r <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                OFS_LINE: line_r <= line_t'(bus_wdata[6:0]);
                OFS_DIVL: div_r[7:0] <= bus_wdata[7:0];
                OFS_DIVH: div_r[DIV_W-1:8] <= bus_wdata[DIV_W-9:0];
                OFS_CTRL: ctrl_r <= bus_wdata[6:0];
                default: ;
            endcase
        end
    end

    ser_baud #(.DW(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .en(ctrl_r[0]), .div(div_r), .tick(tick)
    );

    ser_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(fifo_flush), .single(!line_r.fifo_en),
        .push(wr_data), .din(bus_wdata[7:0]), .pop(tx_pop), .dout(tx_head),
        .count(tx_cnt), .empty(tx_empty), .full(tx_full)
    );

    ser_tx u_tx (
        .clk(clk), .rst(rst), .tick(tick), .en(ctrl_r[0]), .line(line_r),
        .have(!tx_empty), .din(tx_head), .pop(tx_pop), .txd(txd), .busy(tx_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rxd_s1 <= 1'b1;
            rxd_s2 <= 1'b1;
        end else begin
            rxd_s1 <= rxd;
            rxd_s2 <= rxd_s1;
        end
    end

    ser_rx u_rx (
        .clk(clk), .rst(rst), .tick(tick), .en(ctrl_r[0]), .line(line_r),
        .rxd(rxd_s2), .push(rx_push), .word(rx_word), .start_seen(start_seen)
    );

    ser_fifo #(.W($bits(rx_word_t)), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(fifo_flush), .single(!line_r.fifo_en),
        .push(rx_push), .din(rx_word), .pop(rd_data), .dout(rx_head),
        .count(rx_cnt), .empty(rx_empty), .full(rx_full)
    );

    // Error word: overrun is sticky, the head flags can be hidden by a clear write
    always_ff @(posedge clk) begin
        if (rst) begin
            ovr      <= 1'b0;
            err_hide <= 1'b0;
        end else begin
            if (pop_ok || (rx_push && rx_empty) || fifo_flush) err_hide <= 1'b0;
            if (wr_en && (bus_addr == OFS_ERR)) begin
                ovr      <= 1'b0;
                err_hide <= 1'b1;
            end
            if (rx_push && rx_full) ovr <= 1'b1;
        end
    end

    // Receive timeout
    always_ff @(posedge clk) begin
        if (rst) begin
            to_cnt <= '0;
            rtis   <= 1'b0;
        end else begin
            if (rx_empty || start_seen || pop_ok) to_cnt <= '0;
            else if (tick && !rtis)               to_cnt <= to_cnt + 1'b1;
            if (tick && !rx_empty && !rtis && !start_seen && to_cnt == TO_LAST) rtis <= 1'b1;
            if (pop_ok || fifo_flush) rtis <= 1'b0;
        end
    end

    // Modem inputs and change cause
    always_ff @(posedge clk) begin
        if (rst) begin
            mod_now  <= '0;
            mod_prev <= '0;
            mis      <= 1'b0;
        end else begin
            mod_now  <= {dcd, dsr, cts};
            mod_prev <= mod_now;
            if (wr_en && (bus_addr == OFS_INT)) mis <= 1'b0;
            if (mod_now != mod_prev)            mis <= 1'b1;
        end
    end

    assign ris = line_r.fifo_en ? (rx_cnt >= HALF) : !rx_empty;
    assign tis = line_r.fifo_en ? (tx_cnt <= HALF) : tx_empty;
    assign int_view = {rtis & ctrl_r[6], tis & ctrl_r[5], ris & ctrl_r[4], mis & ctrl_r[3]};

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |int_view;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_DATA: bus_rdata[7:0] = rx_empty ? 8'h00 : rx_head.data;
            OFS_ERR:  bus_rdata[3:0] = {ovr, (err_hide || rx_empty) ? 3'b000
                                        : {rx_head.brk, rx_head.perr, rx_head.ferr}};
            OFS_LINE: bus_rdata[6:0] = line_r;
            OFS_DIVH: bus_rdata[DIV_W-9:0] = div_r[DIV_W-1:8];
            OFS_DIVL: bus_rdata[7:0] = div_r[7:0];
            OFS_CTRL: bus_rdata[6:0] = ctrl_r;
            OFS_FLAG: bus_rdata[7:0] = {tx_empty && !tx_busy, 1'b0, tx_full, rx_empty, 1'b0, mod_now};
            OFS_INT:  bus_rdata[3:0] = int_view;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ser_link_chk.sv
module ser_link_chk #(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          txd,
    input logic          irq,
    input logic          brk_cfg,
    input logic          fifo_en,
    input logic          flush,
    input logic          tx_busy,
    input logic          tx_full,
    input logic          tx_push,
    input logic          tx_pop,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic          ris_raw,
    input logic          rx_ie,
    input logic          pop_ok,
    input logic          rtis,
    input logic [2:0]    mod_now,
    input logic [2:0]    mod_prev,
    input logic          mis
);
    p_brk_forces_low_r5: assert property (@(posedge clk) disable iff (rst)
        brk_cfg |=> !txd);

    p_idle_line_high_r3: assert property (@(posedge clk) disable iff (rst)
        (!tx_busy && !brk_cfg) |=> txd);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_full && tx_push && !tx_pop && !flush) |=> $stable(tx_cnt));

    p_single_holding_r8: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |-> (rx_cnt <= CW'(1)));

    p_rx_irq_r10: assert property (@(posedge clk) disable iff (rst)
        (ris_raw && rx_ie) |=> irq);

    p_timeout_cleared_r12: assert property (@(posedge clk) disable iff (rst)
        pop_ok |=> !rtis);

    p_modem_latch_r13: assert property (@(posedge clk) disable iff (rst)
        (mod_now != mod_prev) |=> mis);
endmodule

bind ser_link ser_link_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .txd(txd), .irq(irq),
    .brk_cfg(line_r.brk_tx), .fifo_en(line_r.fifo_en), .flush(fifo_flush),
    .tx_busy(tx_busy), .tx_full(tx_full), .tx_push(wr_data), .tx_pop(tx_pop),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .ris_raw(ris), .rx_ie(ctrl_r[4]),
    .pop_ok(pop_ok), .rtis(rtis), .mod_now(mod_now), .mod_prev(mod_prev), .mis(mis)
);

// File: tb/sim_ser_link.sv
`timescale 1ns/1ps
module sim_ser_link;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, txd, rxd;
    logic        cts = 1'b0, dsr = 1'b0, dcd = 1'b0;
    logic        lb = 1'b0, drv = 1'b1;
    logic        done = 1'b0;
    int          n_tests = 0, n_fail = 0;

    always #2 clk = ~clk;
    assign rxd = lb ? txd : drv;

    ser_link u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rxd(rxd), .txd(txd),
        .cts(cts), .dsr(dsr), .dcd(dcd)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_flag(input int idx, input logic val, input int limit);
        logic [31:0] f;
        for (int i = 0; i < limit; i++) begin
            rd(5'h18, f);
            if (f[idx] == val) return;
        end
    endtask

    function automatic logic par_of(input logic [7:0] d, input int nb, input logic even);
        int ones = 0;
        for (int i = 0; i < nb; i++) ones += d[i];
        return even ? logic'(ones % 2) : logic'(1 - ones % 2);
    endfunction

    // Drive one frame on the receive line, 16 clocks per bit (divisor 0)
    task automatic send(input logic [7:0] d, input int nb, input logic pen, input logic even,
                        input logic badpar, input logic stopv);
        drv = 1'b0; repeat (16) @(negedge clk);
        for (int i = 0; i < nb; i++) begin drv = d[i]; repeat (16) @(negedge clk); end
        if (pen) begin drv = par_of(d, nb, even) ^ badpar; repeat (16) @(negedge clk); end
        drv = stopv; repeat (16) @(negedge clk);
        drv = 1'b1; repeat (32) @(negedge clk);
    endtask

    // Transmit through the loopback and check the serial pattern and the received word
    task automatic frame(input logic [7:0] d, input int wl, input int pm, input int st);
        logic [11:0] e, a;
        logic [31:0] r;
        logic [7:0]  m;
        int n, nb;
        logic pen, even;
        nb = 5 + wl; pen = (pm != 0); even = (pm == 2);
        m = 8'hFF >> (3 - wl);
        e = '0; a = '0; n = 0;
        e[n] = 1'b0; n++;
        for (int i = 0; i < nb; i++) begin e[n] = d[i]; n++; end
        if (pen) begin e[n] = par_of(d, nb, even); n++; end
        for (int i = 0; i <= st; i++) begin e[n] = 1'b1; n++; end
        wr(5'h08, (wl << 5) | (st << 3) | (even << 2) | (pen << 1));
        wr(5'h00, {24'b0, d});
        while (txd) @(negedge clk);
        repeat (8) @(negedge clk);
        a[0] = txd;
        for (int k = 1; k < n; k++) begin repeat (16) @(negedge clk); a[k] = txd; end
        chk("R3", $sformatf("frame wl=%0d pm=%0d st=%0d d=%h", wl, pm, st, d), {20'b0, a}, {20'b0, e});
        wait_flag(4, 1'b0, 60);
        rd(5'h04, r); chk("R4", "loopback error word", r, 32'h0);
        rd(5'h00, r); chk("R4", "loopback data", r, {24'b0, d & m});
        wait_flag(7, 1'b1, 60);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog (all R) actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int cnt, w;
        logic [7:0] pat [4];
        pat[0] = 8'hA5; pat[1] = 8'h3C; pat[2] = 8'hFF; pat[3] = 8'h01;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd(5'h18, r); chk("R1", "flags after reset", r, 32'h90);
        rd(5'h08, r); chk("R1", "line after reset", r, 32'h0);
        rd(5'h04, r); chk("R1", "errors after reset", r, 32'h0);
        rd(5'h1C, r); chk("R1", "interrupts after reset", r, 32'h0);
        chk("R1", "txd idle", {31'b0, txd}, 32'h1);
        chk("R1", "irq idle", {31'b0, irq}, 32'h0);

        // R3 / R4 sweep across all formats in loopback
        lb = 1'b1;
        wr(5'h14, 32'h01);
        for (int wl = 0; wl < 4; wl++)
            for (int pm = 0; pm < 3; pm++)
                for (int st = 0; st < 2; st++)
                    for (int p = 0; p < 4; p++)
                        frame(pat[p], wl, pm, st);

        // R2 divisor sets bit length
        wr(5'h08, 32'h60);
        wr(5'h10, 32'h03); wr(5'h0C, 32'h00);
        rd(5'h10, r); chk("R2", "divisor low readback", r, 32'h3);
        wr(5'h00, 32'h55);
        while (txd) @(negedge clk);
        while (!txd) @(negedge clk);
        cnt = 0;
        while (txd) begin @(negedge clk); cnt++; end
        chk("R2", "bit length divisor 3", cnt, 32'd64);
        wait_flag(7, 1'b1, 400);
        wait_flag(4, 1'b0, 100);
        rd(5'h00, r); chk("R4", "loopback at divisor 3", r, 32'h55);
        wr(5'h10, 32'h00); wr(5'h0C, 32'h01);
        rd(5'h0C, r); chk("R2", "divisor high readback", r, 32'h1);
        wr(5'h00, 32'h55);
        while (txd) @(negedge clk);
        while (!txd) @(negedge clk);
        cnt = 0;
        while (txd) begin @(negedge clk); cnt++; end
        chk("R2", "bit length divisor 256", cnt, 32'd4112);
        wait_flag(7, 1'b1, 30000);
        wait_flag(4, 1'b0, 3000);
        rd(5'h00, r); chk("R4", "loopback at divisor 256", r, 32'h55);
        wr(5'h0C, 32'h00);

        // R5 forced break
        lb = 1'b0;
        wr(5'h08, 32'h61);
        repeat (3) @(negedge clk);
        chk("R5", "txd under break", {31'b0, txd}, 32'h0);
        wr(5'h08, 32'h60);
        repeat (3) @(negedge clk);
        chk("R5", "txd after break", {31'b0, txd}, 32'h1);

        // R6 parity and framing errors, clear by write
        wr(5'h08, 32'h66);
        send(8'h5A, 8, 1, 1, 1, 1);
        rd(5'h04, r); chk("R6", "parity error before pop", r, 32'h2);
        rd(5'h00, r); chk("R6", "data with parity error", r, 32'h5A);
        send(8'h81, 8, 1, 1, 0, 0);
        rd(5'h04, r); chk("R6", "framing error before pop", r, 32'h1);
        wr(5'h04, 32'hFF);
        rd(5'h04, r); chk("R6", "errors after clear write", r, 32'h0);
        rd(5'h00, r); chk("R6", "data with framing error", r, 32'h81);

        // R7 break reception
        send(8'h00, 8, 1, 1, 0, 0);
        rd(5'h04, r); chk("R7", "break only", r, 32'h4);
        rd(5'h00, r); chk("R7", "break data", r, 32'h0);

        // R8 overrun in single mode
        wr(5'h08, 32'h60);
        send(8'h11, 8, 0, 0, 0, 1);
        send(8'h22, 8, 0, 0, 0, 1);
        rd(5'h04, r); chk("R8", "overrun flag", r, 32'h8);
        rd(5'h00, r); chk("R8", "first character kept", r, 32'h11);
        rd(5'h18, r); chk("R8", "second discarded", r & 32'h10, 32'h10);
        wr(5'h04, 32'h0);
        rd(5'h04, r); chk("R8", "overrun cleared", r, 32'h0);

        // R14 glitch rejection
        drv = 1'b0; repeat (5) @(negedge clk); drv = 1'b1;
        repeat (300) @(negedge clk);
        rd(5'h18, r); chk("R14", "glitch gives no character", r & 32'h10, 32'h10);
        send(8'h3C, 8, 0, 0, 0, 1);
        rd(5'h00, r); chk("R14", "frame after glitch", r, 32'h3C);

        // R9 / R10 queue mode depth, order, receive level interrupt
        wr(5'h14, 32'h10);
        wr(5'h08, 32'h70);
        for (int i = 0; i < 16; i++) wr(5'h00, i);
        rd(5'h18, r); chk("R9", "tx queue full flag", r & 32'hA0, 32'h20);
        wr(5'h00, 32'hEE);
        lb = 1'b1;
        wr(5'h14, 32'h11);
        wait_flag(7, 1'b1, 3000);
        repeat (100) @(negedge clk);
        rd(5'h1C, r); chk("R10", "receive level cause", r, 32'h2);
        chk("R10", "irq with receive level", {31'b0, irq}, 32'h1);
        w = 0;
        for (int i = 0; i < 16; i++) begin
            rd(5'h00, r);
            if (r != i) w++;
            if (i == 7) begin
                rd(5'h1C, r); chk("R10", "cause with 8 left", r, 32'h2);
            end
            if (i == 8) begin
                rd(5'h1C, r); chk("R10", "cause with 7 left", r, 32'h0);
                chk("R10", "irq with 7 left", {31'b0, irq}, 32'h0);
            end
        end
        chk("R9", "order of 16 characters", w, 32'd0);
        rd(5'h18, r); chk("R9", "overflow write dropped", r & 32'h10, 32'h10);
        lb = 1'b0;

        // R11 transmit level interrupt
        wr(5'h14, 32'h20);
        rd(5'h1C, r); chk("R11", "tx cause when empty", r, 32'h4);
        chk("R11", "irq tx empty", {31'b0, irq}, 32'h1);
        for (int i = 0; i < 8; i++) wr(5'h00, 32'h40 + i);
        rd(5'h1C, r); chk("R11", "tx cause at 8", r, 32'h4);
        wr(5'h00, 32'h48);
        rd(5'h1C, r); chk("R11", "tx cause at 9", r, 32'h0);
        wr(5'h08, 32'h60);
        rd(5'h18, r); chk("R9", "mode change empties queue", r & 32'hA0, 32'h80);
        rd(5'h1C, r); chk("R11", "single mode empty cause", r, 32'h4);
        wr(5'h00, 32'h77);
        rd(5'h1C, r); chk("R11", "single mode held cause", r, 32'h0);
        rd(5'h18, r); chk("R8", "single mode full", r & 32'h20, 32'h20);
        wr(5'h08, 32'h70);

        // R12 receive timeout
        wr(5'h14, 32'h41);
        send(8'h9C, 8, 0, 0, 0, 1);
        repeat (350) @(negedge clk);
        rd(5'h1C, r); chk("R12", "no timeout yet", r, 32'h0);
        repeat (200) @(negedge clk);
        rd(5'h1C, r); chk("R12", "timeout raised", r, 32'h8);
        chk("R12", "irq on timeout", {31'b0, irq}, 32'h1);
        rd(5'h00, r); chk("R12", "timeout data", r, 32'h9C);
        rd(5'h1C, r); chk("R12", "timeout cleared by read", r, 32'h0);

        // R13 modem inputs
        wr(5'h14, 32'h08);
        cts = 1'b1; repeat (4) @(negedge clk);
        rd(5'h18, r); chk("R13", "clear-to-send flag", r & 32'h7, 32'h1);
        rd(5'h1C, r); chk("R13", "modem cause", r, 32'h1);
        chk("R13", "irq modem", {31'b0, irq}, 32'h1);
        wr(5'h1C, 32'hFF);
        rd(5'h1C, r); chk("R13", "modem cause cleared", r, 32'h0);
        dcd = 1'b1; repeat (4) @(negedge clk);
        rd(5'h18, r); chk("R13", "carrier flag", r & 32'h7, 32'h5);
        rd(5'h1C, r); chk("R13", "second modem cause", r, 32'h1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule